// File: doc/BRIEF.md
# Masked Header Flow Classifier

This block sorts packets into flows by comparing a 112-bit search key against a small table of programmable filter entries, all of them in parallel. The key is assembled inside the block from six input fields: the two IPv4 addresses, the two transport ports, the protocol number, and an 8-bit payload content vector. Each bit of the content vector is set by an upstream payload scanner when the packet matched one signature list.

Each entry holds a 112-bit value, a 112-bit care mask, a 16-bit flow identifier and a live bit. A care bit of 1 forces the key bit to equal the value bit. A care bit of 0 leaves that key bit free. Address prefixes and wildcard fields come from this mask alone. Every entry produces a match line. A priority encoder picks the lowest-numbered matching entry and registers its flow identifier together with a hit flag and a drop mark. Entries are programmed one at a time through a write port.

Top module: `pkt_flow_classifier`

## Requirements
- R1: The key is packed most significant first as source IP [111:80], destination IP [79:48], source port [47:32], destination port [31:16], protocol [15:8], content vector [7:0]. Entry value and mask words use the same bit positions.
- R2: A live entry matches when every key bit whose mask bit is 1 equals the entry's value bit. Key bits under a 0 mask bit are ignored. So a /16 prefix mask matches any low half, and content value/mask 0x01 matches content 0x03.
- R3: When several live entries match, the flow identifier of the lowest-index entry is reported.
- R4: When no entry matches a valid key, res_hit, res_drop and res_flow are all 0.
- R5: A key presented with key_valid high gives its result on the next clock edge, with res_valid high. In a cycle after key_valid was low, res_valid, res_hit, res_drop and res_flow are 0.
- R6: res_drop is 1 exactly when res_hit is 1. A packet that hits a filter is marked to be dropped.
- R7: A write with wr_en high stores wr_value, wr_mask, wr_flow and wr_live in entry wr_idx and replaces what was there. An entry written with wr_live 0 never matches.
- R8: Reset clears the live bit of every entry, so no key matches until entries are written. Reset also clears all outputs to 0.
- R9: A lookup in the same cycle as a write is compared against the table contents from before that write.
- R10: A live entry with an all-zero mask matches every key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write one table entry this cycle |
| wr_idx | input | IDX_W | Entry index to write |
| wr_value | input | 112 | Value word for the entry |
| wr_mask | input | 112 | Care mask for the entry (1 = compare) |
| wr_flow | input | 16 | Flow identifier for the entry |
| wr_live | input | 1 | 1 enables the entry, 0 disables it |
| key_valid | input | 1 | Key fields below are valid for lookup |
| key_src_ip | input | 32 | Source IPv4 address |
| key_dst_ip | input | 32 | Destination IPv4 address |
| key_src_port | input | 16 | Source transport port |
| key_dst_port | input | 16 | Destination transport port |
| key_proto | input | 8 | IP protocol number |
| key_content | input | 8 | Payload signature-list hit bits |
| res_valid | output | 1 | Result of the previous cycle's key |
| res_hit | output | 1 | Some live entry matched |
| res_drop | output | 1 | Packet marked for dropping |
| res_flow | output | 16 | Flow identifier of the winning entry, 0 on miss |

## Verification
There is one register stage between a key and its result. A write also lands on the same edge. The bench drives every input just after a falling edge. From the table as it stood before that edge, it works out the result due at the next rising edge, and only then applies any write to its own copy of the table. It compares all four result outputs at the following falling edge. So every cycle is checked exactly one edge after its stimulus. The same ordering gives the check for R9: a write in a lookup cycle is not yet visible to that lookup.

// File: rtl/cls_pkg.sv
package cls_pkg;
  localparam int IP_W    = 32;
  localparam int PORT_W  = 16;
  localparam int PROTO_W = 8;
  localparam int CONT_W  = 8;
  localparam int FLOW_W  = 16;
  localparam int KEY_W   = 2 * IP_W + 2 * PORT_W + PROTO_W + CONT_W;

  typedef struct packed {
    logic [IP_W-1:0]    src_ip;
    logic [IP_W-1:0]    dst_ip;
    logic [PORT_W-1:0]  src_port;
    logic [PORT_W-1:0]  dst_port;
    logic [PROTO_W-1:0] proto;
    logic [CONT_W-1:0]  content;
  } hdr_key_t;

  // True when every cared bit of the key agrees with the stored value.
  function automatic logic masked_eq(input logic [KEY_W-1:0] key,
                                     input logic [KEY_W-1:0] value,
                                     input logic [KEY_W-1:0] mask);
    return ((key ^ value) & mask) == '0;
  endfunction
endpackage

// File: rtl/cls_entry.sv
module cls_entry
  import cls_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sel,
  input  logic [KEY_W-1:0]  wr_value,
  input  logic [KEY_W-1:0]  wr_mask,
  input  logic [FLOW_W-1:0] wr_flow,
  input  logic              wr_live,
  input  logic [KEY_W-1:0]  key,
  output logic              match,
  output logic [FLOW_W-1:0] flow
);
  logic [KEY_W-1:0]  value_q;
  logic [KEY_W-1:0]  mask_q;
  logic [FLOW_W-1:0] flow_q;
  logic              live_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value_q <= '0;
      mask_q  <= '0;
      flow_q  <= '0;
      live_q  <= 1'b0;
    end else if (wr_sel) begin
      value_q <= wr_value;
      mask_q  <= wr_mask;
      flow_q  <= wr_flow;
      live_q  <= wr_live;
    end
  end

  assign match = live_q && masked_eq(key, value_q, mask_q);
  assign flow  = flow_q;

  // R7: an entry just written as disabled cannot match any key
  a_r7_dead_entry_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel && !wr_live) |=> !match);

  // R8: the cycle after reset no entry matches
  a_r8_reset_kills_entry: assert property (@(posedge clk)
    !rst_n |=> !match);
endmodule

// File: rtl/cls_prio.sv
module cls_prio #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  localparam logic [N-1:0] ONE = 1;

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

  // R3: the chosen index is a requester and no lower index requests
  always_comb begin
    if (any) begin
      a_r3_grant_is_request: assert (req[idx]);
      a_r3_nothing_below: assert ((req & ((ONE << idx) - ONE)) == '0);
    end else begin
      a_r4_idle_no_request: assert (req == '0);
    end
  end
endmodule

// File: rtl/pkt_flow_classifier.sv
module pkt_flow_classifier
  import cls_pkg::*;
#(
  parameter  int ENTRIES = 8,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [KEY_W-1:0]    wr_value,
  input  logic [KEY_W-1:0]    wr_mask,
  input  logic [FLOW_W-1:0]   wr_flow,
  input  logic                wr_live,
  input  logic                key_valid,
  input  logic [IP_W-1:0]     key_src_ip,
  input  logic [IP_W-1:0]     key_dst_ip,
  input  logic [PORT_W-1:0]   key_src_port,
  input  logic [PORT_W-1:0]   key_dst_port,
  input  logic [PROTO_W-1:0]  key_proto,
  input  logic [CONT_W-1:0]   key_content,
  output logic                res_valid,
  output logic                res_hit,
  output logic                res_drop,
  output logic [FLOW_W-1:0]   res_flow
);
  hdr_key_t          key_s;
  logic [ENTRIES-1:0] match_lines;
  logic [FLOW_W-1:0]  entry_flow [ENTRIES];
  logic               win_any;
  logic [IDX_W-1:0]   win_idx;
  logic [FLOW_W-1:0]  win_flow;

  always_comb begin
    key_s.src_ip   = key_src_ip;
    key_s.dst_ip   = key_dst_ip;
    key_s.src_port = key_src_port;
    key_s.dst_port = key_dst_port;
    key_s.proto    = key_proto;
    key_s.content  = key_content;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(g));
    cls_entry u_entry (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_sel   (sel),
      .wr_value (wr_value),
      .wr_mask  (wr_mask),
      .wr_flow  (wr_flow),
      .wr_live  (wr_live),
      .key      (key_s),
      .match    (match_lines[g]),
      .flow     (entry_flow[g])
    );
  end

  cls_prio #(.N(ENTRIES), .IDX_W(IDX_W)) u_prio (
    .req (match_lines),
    .any (win_any),
    .idx (win_idx)
  );

  assign win_flow = win_any ? entry_flow[win_idx] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_drop  <= 1'b0;
      res_flow  <= '0;
    end else begin
      res_valid <= key_valid;
      res_hit   <= key_valid && win_any;
      res_drop  <= key_valid && win_any;
      res_flow  <= key_valid ? win_flow : '0;
    end
  end

  // R5: one-cycle result timing
  a_r5_result_follows_key: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> res_valid);
  a_r5_quiet_without_key: assert property (@(posedge clk) disable iff (!rst_n)
    !key_valid |=> (!res_valid && !res_hit && res_flow == '0));
  // R4: a miss reports flow 0 and no drop
  a_r4_miss_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_flow == '0 && !res_drop));
  // R6: drop mark travels with the hit flag
  a_r6_drop_tracks_hit: assert property (@(posedge clk) disable iff (!rst_n)
    res_drop == res_hit);
  // R8: the first cycle out of reset reports nothing
  a_r8_outputs_cleared: assert property (@(posedge clk)
    !rst_n |=> (!res_valid && !res_hit && !res_drop));
endmodule

// File: tb/sim_pkt_flow_classifier.sv
module sim_pkt_flow_classifier;
  localparam int PERIOD = 10;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_idx = '0;
  logic [111:0] wr_value = '0;
  logic [111:0] wr_mask = '0;
  logic [15:0]  wr_flow = '0;
  logic         wr_live = 1'b0;
  logic         key_valid = 1'b0;
  logic [31:0]  key_src_ip = '0, key_dst_ip = '0;
  logic [15:0]  key_src_port = '0, key_dst_port = '0;
  logic [7:0]   key_proto = '0, key_content = '0;
  logic         res_valid, res_hit, res_drop;
  logic [15:0]  res_flow;

  int checks = 0;
  int fails = 0;

  logic [111:0] m_val [N];
  logic [111:0] m_msk [N];
  logic [15:0]  m_flow [N];
  bit           m_live [N];

  always #(PERIOD/2) clk = ~clk;

  pkt_flow_classifier #(.ENTRIES(N)) u0 (
    .clk, .rst_n, .wr_en, .wr_idx, .wr_value, .wr_mask, .wr_flow, .wr_live,
    .key_valid, .key_src_ip, .key_dst_ip, .key_src_port, .key_dst_port,
    .key_proto, .key_content, .res_valid, .res_hit, .res_drop, .res_flow
  );

  function automatic logic [111:0] mk_key(input logic [31:0] s, input logic [31:0] d,
      input logic [15:0] sp, input logic [15:0] dp, input logic [7:0] pr, input logic [7:0] ct);
    return {s, d, sp, dp, pr, ct};
  endfunction

  task automatic check(input string tag, input logic [18:0] got, input logic [18:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: {valid,hit,drop,flow} actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // One clock: drive, predict from the old table, update the model, check.
  task automatic step(input bit kv, input logic [111:0] k, input bit we, input int wi,
      input logic [111:0] wv, input logic [111:0] wm, input logic [15:0] wf,
      input bit wl, input string tag);
    bit e_hit = 0;
    logic [15:0] e_flow = '0;
    key_valid = kv;
    {key_src_ip, key_dst_ip, key_src_port, key_dst_port, key_proto, key_content} = k;
    wr_en = we; wr_idx = 3'(wi); wr_value = wv; wr_mask = wm; wr_flow = wf; wr_live = wl;
    if (kv) begin
      for (int i = 0; i < N; i++) begin
        bit ok = m_live[i];
        for (int b = 0; b < 112; b++)
          if (m_msk[i][b] && (k[b] != m_val[i][b])) ok = 0;
        if (ok && !e_hit) begin
          e_hit = 1;
          e_flow = m_flow[i];
        end
      end
    end
    if (we) begin
      m_val[wi] = wv; m_msk[wi] = wm; m_flow[wi] = wf; m_live[wi] = wl;
    end
    @(negedge clk);
    check(tag, {res_valid, res_hit, res_drop, res_flow}, {kv, e_hit, e_hit, e_flow});
  endtask

  task automatic look(input logic [111:0] k, input string tag);
    step(1, k, 0, 0, '0, '0, '0, 0, tag);
  endtask

  task automatic put(input int wi, input logic [111:0] wv, input logic [111:0] wm,
      input logic [15:0] wf, input bit wl, input string tag);
    step(0, '0, 1, wi, wv, wm, wf, wl, tag);
  endtask

  task automatic do_reset();
    wr_en = 0; key_valid = 0;
    rst_n = 0;
    for (int i = 0; i < N; i++) m_live[i] = 0;
    @(negedge clk); @(negedge clk);
    check("R8 reset outputs", {res_valid, res_hit, res_drop, res_flow}, '0);
    rst_n = 1;
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [111:0] pkt, pkt2, f_val, f_msk, k;
    for (int i = 0; i < N; i++) begin
      m_val[i] = '0; m_msk[i] = '0; m_flow[i] = '0; m_live[i] = 0;
    end
    pkt  = mk_key(32'h80FC0505, 32'h8D8E0202, 16'h1000, 16'h0050, 8'h06, 8'h03);
    pkt2 = mk_key(32'h0A000001, 32'h0A000002, 16'h1234, 16'h0050, 8'h11, 8'h00);
    @(negedge clk);
    do_reset();

    look(pkt, "R8 empty table misses");
    // R1 R2: /16 prefixes, wildcard source port, content list 0 only
    f_val = mk_key(32'h80FC0000, 32'h8D8E0000, 16'h0000, 16'h0050, 8'h06, 8'h01);
    f_msk = mk_key(32'hFFFF0000, 32'hFFFF0000, 16'h0000, 16'hFFFF, 8'hFF, 8'h01);
    put(2, f_val, f_msk, 16'h0A11, 1, "R7 write entry 2");
    look(pkt, "R2 R6 prefix and content 0x03 hit");
    look(mk_key(32'h80FC0505, 32'h8D8E0202, 16'h1000, 16'h0050, 8'h06, 8'h02),
         "R4 content without list 0 misses");
    look(mk_key(32'h80FD0505, 32'h8D8E0202, 16'h1000, 16'h0050, 8'h06, 8'h01),
         "R2 prefix mismatch misses");
    // R10: all-zero mask catches everything; R3: entry 2 outranks entry 5
    put(5, '0, '0, 16'h0555, 1, "R7 write catch-all entry 5");
    look(pkt, "R3 lower index wins over catch-all");
    look(pkt2, "R10 catch-all matches other key");
    // R1: care only about the source IP field
    put(0, mk_key(32'h80FC0505, 0, 0, 0, 0, 0), mk_key(32'hFFFFFFFF, 0, 0, 0, 0, 0),
        16'h0001, 1, "R7 write entry 0");
    look(pkt, "R1 R3 source IP field hit on entry 0");
    look(mk_key(32'h01020304, 32'h80FC0505, 16'h1000, 16'h0050, 8'h06, 8'h03),
         "R1 same value in dst field skips entry 0");
    // R9: disable entry 0 while looking up
    step(1, pkt, 1, 0, '0, '0, 16'h0BAD, 0, "R9 lookup sees table before write");
    look(pkt, "R7 disabled entry no longer matches");
    step(0, pkt, 0, 0, '0, '0, '0, 0, "R5 no key gives idle result");
    put(5, '0, '0, 16'h0555, 0, "R7 disable catch-all");
    look(pkt2, "R4 miss after disable");
    put(3, mk_key(0, 0, 0, 0, 8'h11, 0), mk_key(0, 0, 0, 0, 8'hFF, 0),
        16'h0333, 1, "R7 overwrite-ready entry 3");
    look(pkt2, "R2 protocol-only entry hit");

    for (int n = 0; n < 120; n++) begin
      logic [31:0] ips [4] = '{32'h80FC0505, 32'h8D8E0202, 32'h0A000001, 32'hC0A80001};
      logic [15:0] prt [2] = '{16'h0050, 16'h1000};
      k = mk_key(ips[$urandom % 4], ips[$urandom % 4], prt[$urandom % 2], prt[$urandom % 2],
                 (($urandom % 2) == 0) ? 8'h06 : 8'h11, 8'($urandom % 4));
      if (($urandom % 3) == 0) begin
        logic [5:0] c = 6'($urandom);
        f_msk = mk_key({32{c[0]}}, {32{c[1]}}, {16{c[2]}}, {16{c[3]}}, {8{c[4]}}, {8{c[5]}});
        step(($urandom % 2) == 1, k, 1, int'($urandom % N), k, f_msk, 16'($urandom),
             ($urandom % 4) != 0, "R3 R9 mixed random write");
      end else begin
        look(k, "R2 R3 random lookup");
      end
    end

    do_reset();
    look(pkt, "R8 reset empties table");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule